// File: doc/BRIEF.md
# Pointer Load/Store Address Unit

This block forms the memory address for every data-memory and program-memory load or store of a small 8-bit processor core. It also keeps the three 16-bit pointer registers (X, Y, Z) up to date. The decoder hands it one access command at a time. The command carries a mode, a pointer select, a 6-bit displacement, a full 16-bit direct address, a destination register, store data and a 16-bit pair value.

The block drives a synchronous data memory (byte wide) and a synchronous program memory (16-bit words). It returns loaded bytes, or a copied register pair, to the register file on a write-back port. A `busy` pin is high on every cycle of an operation except the last, and a `done` pin pulses on the last cycle.

Commands enter on a valid/ready handshake. `cmd_ready` is high only while the unit is idle. A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high. While the unit is working, the decoder must hold or withhold the next command; nothing is lost, because `cmd_ready` stays low until the current operation has retired. The command fields are captured at acceptance and may change afterwards.

Top module: `lsu_ptr_unit`

## Requirements
- R1: After reset the unit is idle. `cmd_ready` is 1. `busy`, `done`, `dmem_re`, `dmem_we`, `pmem_re` and `rf_we` are 0. All three pointers read as 0x0000.
- R2: The pointer registers are built from register pairs, written high:low. X is r27:r26, Y is r29:r28 and Z is r31:r30. `cmd_ptr` selects 0 = X, 1 = Y, 2 = Z. Any write-back to one of these registers, whether a single byte or a pair, changes that pointer byte at the same commit.
- R3: Plain mode (`cmd_mode` 0) accesses the address held in the selected pointer and leaves the pointer unchanged. A load raises `dmem_re` in the first cycle. In the second cycle it asserts `done` and writes the read byte, zero-extended, to register `cmd_reg`. A data access never raises `dmem_re` and `dmem_we` together.
- R4: Post-increment mode (1) accesses the current pointer value. When `done` is high, the pointer becomes that value plus one, modulo 2^16.
- R5: Pre-decrement mode (2) accesses the pointer minus one, modulo 2^16. The pointer keeps that decremented value.
- R6: Displacement mode (3) is used only with Y or Z. It accesses the pointer plus `cmd_disp`, an unsigned value from 0 to 63, with the sum taken modulo 2^16. The pointer is left unchanged.
- R7: Direct mode (4) accesses `cmd_addr` and touches no pointer. A store, in any data mode, drives `dmem_we`, `dmem_addr` and `dmem_wdata` in its first cycle. It asserts `done` in its second cycle and makes no register write-back.
- R8: Pair copy (mode 8) completes in the cycle after acceptance. In that cycle `rf_we` and `rf_wpair` are 1, `rf_waddr` is `cmd_reg` and `rf_wdata` is `cmd_pair`.
- R9: The program-memory read modes always use Z.
  - In all three modes, the first cycle drives `pmem_re` with `pmem_addr` = Z[15:1].
  - `done` comes in the third cycle. The byte written back is the high half of the word when Z[0] is 1 and the low half when it is 0.
  - Mode 5 writes to `cmd_reg` and leaves Z alone.
  - Mode 6 does the same as mode 5, then increments Z.
  - Mode 7 always writes to register 0.
- R10: `busy` is 1 on every cycle of an operation before its last, and 0 on the last. `done` is 1 only on the last cycle. Register write-back and pointer update happen only on the `done` cycle.
- R11: `cmd_ready` is 0 from the cycle after acceptance until the operation's last cycle, inclusive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Unit idle, command will be taken |
| cmd_mode | input | 4 | Access mode code |
| cmd_ptr | input | 2 | Pointer select (0 X, 1 Y, 2 Z) |
| cmd_write | input | 1 | 1 = store, 0 = load (data modes) |
| cmd_disp | input | 6 | Unsigned displacement |
| cmd_addr | input | 16 | Direct data address |
| cmd_reg | input | 5 | Destination register index |
| cmd_wdata | input | 8 | Store data |
| cmd_pair | input | 16 | Pair value for copy |
| busy | output | 1 | Operation in progress, not in final cycle |
| done | output | 1 | Final cycle of an operation |
| dmem_addr | output | 16 | Data memory address |
| dmem_re | output | 1 | Data memory read strobe |
| dmem_we | output | 1 | Data memory write strobe |
| dmem_wdata | output | 8 | Data memory write data |
| dmem_rdata | input | 8 | Data memory read data, one cycle after `dmem_re` |
| pmem_addr | output | 15 | Program memory word address |
| pmem_re | output | 1 | Program memory read strobe |
| pmem_rdata | input | 16 | Program memory word, one cycle after `pmem_re` |
| rf_we | output | 1 | Register file write enable |
| rf_waddr | output | 5 | Register file write index (low register of a pair) |
| rf_wpair | output | 1 | Write covers two registers |
| rf_wdata | output | 16 | Write-back data (byte zero-extended, or pair) |

## Verification
The assertions take both memories to answer with read data exactly one cycle after the read strobe. They also take it that the decoder never issues a displacement command naming X, or a `cmd_ptr` of 3. They further assume that no load into a pointer's own register uses that same pointer in post-increment or pre-decrement mode. Every directed command the bench issues obeys these rules. The bench also starts each command only after seeing `cmd_ready` high, so acceptance always happens on the next edge.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  localparam int LSU_DW       = 8;
  localparam int LSU_AW       = 2 * LSU_DW;
  localparam int LSU_QW       = 6;
  localparam int LSU_RW       = 5;
  localparam int LSU_NPTR     = 3;
  localparam int LSU_PTR_BASE = 26;

  typedef enum logic [3:0] {
    M_PLAIN    = 4'd0,
    M_POSTINC  = 4'd1,
    M_PREDEC   = 4'd2,
    M_DISP     = 4'd3,
    M_DIRECT   = 4'd4,
    M_PROG     = 4'd5,
    M_PROG_INC = 4'd6,
    M_PROG_R0  = 4'd7,
    M_COPY     = 4'd8
  } lsu_mode_e;

  typedef struct packed {
    lsu_mode_e             mode;
    logic [1:0]            sel;
    logic                  wr;
    logic [LSU_QW-1:0]     q;
    logic [LSU_AW-1:0]     k;
    logic [LSU_RW-1:0]     rd;
    logic [LSU_DW-1:0]     wdata;
    logic [LSU_AW-1:0]     pair;
  } lsu_cmd_t;

  function automatic logic lsu_is_prog(lsu_mode_e m);
    return (m == M_PROG) || (m == M_PROG_INC) || (m == M_PROG_R0);
  endfunction

  // index of the final step of an operation
  function automatic logic [1:0] lsu_last_step(lsu_mode_e m);
    if (m == M_COPY) return 2'd0;
    if (lsu_is_prog(m)) return 2'd2;
    return 2'd1;
  endfunction
endpackage

// File: rtl/lsu_ptr_file.sv
module lsu_ptr_file #(
  parameter int DW    = lsu_pkg::LSU_DW,
  parameter int RW    = lsu_pkg::LSU_RW,
  parameter int NPTR  = lsu_pkg::LSU_NPTR,
  parameter int BASE  = lsu_pkg::LSU_PTR_BASE,
  localparam int AW   = 2 * DW
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wb_we,
  input  logic                     wb_pair,
  input  logic [RW-1:0]            wb_addr,
  input  logic [AW-1:0]            wb_data,
  input  logic                     upd_en,
  input  logic [1:0]               upd_sel,
  input  logic [AW-1:0]            upd_val,
  output logic [NPTR-1:0][AW-1:0]  ptrs
);
  for (genvar i = 0; i < NPTR; i++) begin : g_ptr
    localparam logic [RW-1:0] LO_IDX = RW'(BASE + 2*i);
    localparam logic [RW-1:0] HI_IDX = RW'(BASE + 2*i + 1);
    logic [AW-1:0] nxt;

    always_comb begin
      nxt = ptrs[i];
      if (wb_we && wb_pair && wb_addr == LO_IDX) begin
        nxt = wb_data;
      end else if (wb_we && !wb_pair && wb_addr == LO_IDX) begin
        nxt[DW-1:0] = wb_data[DW-1:0];
      end else if (wb_we && !wb_pair && wb_addr == HI_IDX) begin
        nxt[AW-1:DW] = wb_data[DW-1:0];
      end
      // own address update takes precedence over a byte write-back
      if (upd_en && upd_sel == 2'(i)) nxt = upd_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ptrs[i] <= '0;
      else        ptrs[i] <= nxt;
    end
  end
endmodule

// File: rtl/lsu_addr_gen.sv
module lsu_addr_gen
  import lsu_pkg::*;
#(
  parameter int AW = LSU_AW,
  parameter int QW = LSU_QW
) (
  input  lsu_mode_e       mode,
  input  logic [AW-1:0]   base,
  input  logic [QW-1:0]   disp,
  input  logic [AW-1:0]   direct,
  output logic [AW-1:0]   ea,
  output logic [AW-1:0]   nxt,
  output logic            moves
);
  logic [AW-1:0] inc, dec;
  assign inc = base + AW'(1);
  assign dec = base - AW'(1);

  always_comb begin
    ea    = base;
    nxt   = base;
    moves = 1'b0;
    unique case (mode)
      M_POSTINC, M_PROG_INC: begin nxt = inc; moves = 1'b1; end
      M_PREDEC:   begin ea = dec; nxt = dec; moves = 1'b1; end
      M_DISP:     ea = base + {{(AW-QW){1'b0}}, disp};
      M_DIRECT:   ea = direct;
      default:    ;
    endcase
  end
endmodule

// File: rtl/lsu_seq.sv
module lsu_seq
  import lsu_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  input  lsu_cmd_t    cmd_in,
  output logic        cmd_ready,
  output lsu_cmd_t    cmd_q,
  output logic [1:0]  step,
  output logic        active,
  output logic        busy,
  output logic        done
);
  logic last;
  assign last      = active && (step == lsu_last_step(cmd_q.mode));
  assign cmd_ready = !active;
  assign busy      = active && !last;
  assign done      = last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      step   <= '0;
      cmd_q  <= '0;
    end else if (!active) begin
      step <= '0;
      if (cmd_valid) begin
        active <= 1'b1;
        cmd_q  <= cmd_in;
      end
    end else if (last) begin
      active <= 1'b0;
      step   <= '0;
    end else begin
      step <= step + 2'd1;
    end
  end
endmodule

// File: rtl/lsu_ptr_unit.sv
module lsu_ptr_unit
  import lsu_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_valid,
  output logic                 cmd_ready,
  input  logic [3:0]           cmd_mode,
  input  logic [1:0]           cmd_ptr,
  input  logic                 cmd_write,
  input  logic [LSU_QW-1:0]    cmd_disp,
  input  logic [LSU_AW-1:0]    cmd_addr,
  input  logic [LSU_RW-1:0]    cmd_reg,
  input  logic [LSU_DW-1:0]    cmd_wdata,
  input  logic [LSU_AW-1:0]    cmd_pair,
  output logic                 busy,
  output logic                 done,
  output logic [LSU_AW-1:0]    dmem_addr,
  output logic                 dmem_re,
  output logic                 dmem_we,
  output logic [LSU_DW-1:0]    dmem_wdata,
  input  logic [LSU_DW-1:0]    dmem_rdata,
  output logic [LSU_AW-2:0]    pmem_addr,
  output logic                 pmem_re,
  input  logic [LSU_AW-1:0]    pmem_rdata,
  output logic                 rf_we,
  output logic [LSU_RW-1:0]    rf_waddr,
  output logic                 rf_wpair,
  output logic [LSU_AW-1:0]    rf_wdata
);
  localparam int DW = LSU_DW;
  localparam int AW = LSU_AW;
  localparam logic [1:0] Z_SEL = 2'd2;

  lsu_cmd_t cmd_in, cmd_q;
  logic [1:0] step;
  logic active, first;
  logic is_prog, is_copy, is_data, is_load;
  logic [1:0] sel_eff;
  logic [LSU_NPTR-1:0][AW-1:0] ptrs;
  logic [AW-1:0] base, ea, nxt, word_q;
  logic moves;

  always_comb begin
    cmd_in       = '0;
    cmd_in.mode  = lsu_mode_e'(cmd_mode);
    cmd_in.sel   = cmd_ptr;
    cmd_in.wr    = cmd_write;
    cmd_in.q     = cmd_disp;
    cmd_in.k     = cmd_addr;
    cmd_in.rd    = cmd_reg;
    cmd_in.wdata = cmd_wdata;
    cmd_in.pair  = cmd_pair;
  end

  lsu_seq u_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_in(cmd_in),
    .cmd_ready(cmd_ready), .cmd_q(cmd_q), .step(step), .active(active),
    .busy(busy), .done(done)
  );

  assign is_prog = lsu_is_prog(cmd_q.mode);
  assign is_copy = (cmd_q.mode == M_COPY);
  assign is_data = !is_prog && !is_copy;
  assign is_load = is_data && !cmd_q.wr;
  assign first   = active && (step == 2'd0);
  assign sel_eff = is_prog ? Z_SEL : cmd_q.sel;

  always_comb begin
    unique case (sel_eff)
      2'd0:    base = ptrs[0];
      2'd1:    base = ptrs[1];
      default: base = ptrs[2];
    endcase
  end

  lsu_addr_gen u_agen (
    .mode(cmd_q.mode), .base(base), .disp(cmd_q.q), .direct(cmd_q.k),
    .ea(ea), .nxt(nxt), .moves(moves)
  );

  // data memory side
  assign dmem_addr  = ea;
  assign dmem_re    = first && is_load;
  assign dmem_we    = first && is_data && cmd_q.wr;
  assign dmem_wdata = cmd_q.wdata;

  // program memory side, always through Z
  assign pmem_addr = ptrs[2][AW-1:1];
  assign pmem_re   = first && is_prog;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                               word_q <= '0;
    else if (active && step == 2'd1 && is_prog) word_q <= pmem_rdata;
  end

  // register write-back on the final cycle only
  assign rf_we    = done && (is_copy || is_prog || is_load);
  assign rf_wpair = done && is_copy;
  assign rf_waddr = (cmd_q.mode == M_PROG_R0) ? '0 : cmd_q.rd;

  always_comb begin
    if (is_copy)      rf_wdata = cmd_q.pair;
    else if (is_prog) rf_wdata = {{DW{1'b0}}, (ptrs[2][0] ? word_q[AW-1:DW] : word_q[DW-1:0])};
    else              rf_wdata = {{DW{1'b0}}, dmem_rdata};
  end

  lsu_ptr_file u_ptrs (
    .clk(clk), .rst_n(rst_n),
    .wb_we(rf_we), .wb_pair(rf_wpair), .wb_addr(rf_waddr), .wb_data(rf_wdata),
    .upd_en(done && moves && !is_copy), .upd_sel(sel_eff), .upd_val(nxt),
    .ptrs(ptrs)
  );
endmodule

// File: rtl/lsu_ptr_unit_chk.sv
module lsu_ptr_unit_chk (
  input logic clk,
  input logic rst_n,
  input logic cmd_valid,
  input logic cmd_ready,
  input logic busy,
  input logic done,
  input logic dmem_re,
  input logic dmem_we,
  input logic pmem_re,
  input logic rf_we,
  input logic rf_wpair
);
  AST_LOAD_TWO_CYC: assert property (@(posedge clk) disable iff (!rst_n)
    dmem_re |=> done && rf_we && !rf_wpair); // R3
  AST_NO_DUAL_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !(dmem_re && dmem_we)); // R3
  AST_STORE_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
    dmem_we |=> done && !rf_we); // R7
  AST_COPY_ONE_CYC: assert property (@(posedge clk) disable iff (!rst_n)
    rf_wpair |-> rf_we && $past(cmd_valid && cmd_ready)); // R8
  AST_PROG_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    pmem_re |=> busy && !rf_we); // R9
  AST_PROG_THREE_CYC: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pmem_re, 2) |-> done && rf_we); // R9
  AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done)); // R10
  AST_WB_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> done); // R10
  AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> !busy && !done); // R11
endmodule

bind lsu_ptr_unit lsu_ptr_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .busy(busy), .done(done), .dmem_re(dmem_re), .dmem_we(dmem_we),
  .pmem_re(pmem_re), .rf_we(rf_we), .rf_wpair(rf_wpair)
);

// File: tb/sim_lsu_ptr_unit.sv
module sim_lsu_ptr_unit;
  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] PLAIN = 0, POSTINC = 1, PREDEC = 2, DISP = 3, DIRECT = 4,
                         PROG = 5, PROG_INC = 6, PROG_R0 = 7, COPY = 8;
  localparam logic [1:0] PX = 0, PY = 1, PZ = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_ready, cmd_write = 1'b0;
  logic [3:0] cmd_mode = '0;
  logic [1:0] cmd_ptr = '0;
  logic [5:0] cmd_disp = '0;
  logic [15:0] cmd_addr = '0, cmd_pair = '0;
  logic [4:0] cmd_reg = '0;
  logic [7:0] cmd_wdata = '0;
  logic busy, done, dmem_re, dmem_we, pmem_re, rf_we, rf_wpair;
  logic [15:0] dmem_addr, rf_wdata, pmem_rdata;
  logic [7:0] dmem_wdata, dmem_rdata;
  logic [14:0] pmem_addr;
  logic [4:0] rf_waddr;

  logic [7:0]  dmem [256];
  logic [15:0] pmem [128];

  int total = 0, failn = 0;
  bit finished = 0;

  // sampled results of the last operation
  logic [15:0] f_addr, o_wdata;
  logic [14:0] f_paddr;
  logic [7:0]  f_wd;
  logic f_re, f_we, f_pre, o_we, o_wpair;
  logic [4:0] o_waddr;
  int ncyc;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] dinit(int i);
    return 8'(i * 7 + 3);
  endfunction
  function automatic logic [15:0] pinit(int i);
    return {8'(i + 8'h80), 8'(i) ^ 8'h3C};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) dmem[i] <= dinit(i);
      for (int i = 0; i < 128; i++) pmem[i] <= pinit(i);
      dmem_rdata <= '0;
      pmem_rdata <= '0;
    end else begin
      if (dmem_re) dmem_rdata <= dmem[dmem_addr[7:0]];
      if (dmem_we) dmem[dmem_addr[7:0]] <= dmem_wdata;
      if (pmem_re) pmem_rdata <= pmem[pmem_addr[6:0]];
    end
  end

  lsu_ptr_unit u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_mode(cmd_mode), .cmd_ptr(cmd_ptr), .cmd_write(cmd_write), .cmd_disp(cmd_disp),
    .cmd_addr(cmd_addr), .cmd_reg(cmd_reg), .cmd_wdata(cmd_wdata), .cmd_pair(cmd_pair),
    .busy(busy), .done(done), .dmem_addr(dmem_addr), .dmem_re(dmem_re), .dmem_we(dmem_we),
    .dmem_wdata(dmem_wdata), .dmem_rdata(dmem_rdata), .pmem_addr(pmem_addr),
    .pmem_re(pmem_re), .pmem_rdata(pmem_rdata), .rf_we(rf_we), .rf_waddr(rf_waddr),
    .rf_wpair(rf_wpair), .rf_wdata(rf_wdata)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      failn++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic do_op(input logic [3:0] m, input logic [1:0] p, input logic w,
                       input logic [5:0] q, input logic [15:0] k, input logic [4:0] rd,
                       input logic [7:0] wd, input logic [15:0] pr);
    bit busy_bad = 0;
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_mode = m; cmd_ptr = p; cmd_write = w; cmd_disp = q; cmd_addr = k;
    cmd_reg = rd; cmd_wdata = wd; cmd_pair = pr; cmd_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_mode = '0; cmd_addr = '0; cmd_pair = '0; cmd_reg = '0; cmd_disp = '0;
    f_addr = dmem_addr; f_re = dmem_re; f_we = dmem_we; f_wd = dmem_wdata;
    f_paddr = pmem_addr; f_pre = pmem_re;
    chk("R11", "ready low while working", 32'(cmd_ready), 0);
    ncyc = 1;
    while (!done && ncyc < 6) begin
      if (!busy) busy_bad = 1;
      @(negedge clk);
      ncyc++;
    end
    chk("R10", "busy on early cycles, low on last", 32'(busy_bad || busy), 0);
    o_we = rf_we; o_waddr = rf_waddr; o_wpair = rf_wpair; o_wdata = rf_wdata;
  endtask

  task automatic set_ptr(input logic [4:0] lo_reg, input logic [15:0] v);
    do_op(COPY, PX, 0, 0, 0, lo_reg, 0, v);
  endtask

  task automatic check_ptr(input logic [1:0] p, input logic [15:0] exp, input string req);
    do_op(PLAIN, p, 0, 0, 0, 5'd1, 0, 0);
    chk(req, "pointer value seen on address", 32'(f_addr), 32'(exp));
  endtask

  task automatic t_reset;
    chk("R1", "ready", 32'(cmd_ready), 1);
    chk("R1", "busy/done", {busy, done}, 0);
    chk("R1", "strobes", {dmem_re, dmem_we, pmem_re, rf_we}, 0);
    check_ptr(PX, 16'h0000, "R1");
    check_ptr(PZ, 16'h0000, "R1");
  endtask

  task automatic t_copy;
    set_ptr(5'd26, 16'h0040);
    chk("R8", "cycles", ncyc, 1);
    chk("R8", "we/pair", {o_we, o_wpair}, 2'b11);
    chk("R8", "waddr", 32'(o_waddr), 26);
    chk("R8", "wdata", 32'(o_wdata), 32'h0040);
    check_ptr(PX, 16'h0040, "R2");
  endtask

  task automatic t_plain;
    do_op(PLAIN, PX, 0, 0, 0, 5'd5, 0, 0);
    chk("R3", "address", 32'(f_addr), 32'h40);
    chk("R3", "read strobe", {f_re, f_we}, 2'b10);
    chk("R3", "cycles", ncyc, 2);
    chk("R3", "write-back", {o_we, o_wpair, 3'b0, o_waddr}, {2'b10, 3'b0, 5'd5});
    chk("R3", "loaded byte", 32'(o_wdata), 32'(dinit(8'h40)));
    check_ptr(PX, 16'h0040, "R3");
  endtask

  task automatic t_postinc;
    set_ptr(5'd28, 16'hFFFF);
    do_op(POSTINC, PY, 0, 0, 0, 5'd4, 0, 0);
    chk("R4", "address uses old value", 32'(f_addr), 32'hFFFF);
    chk("R4", "loaded byte", 32'(o_wdata), 32'(dinit(8'hFF)));
    check_ptr(PY, 16'h0000, "R4");
    do_op(POSTINC, PY, 1, 0, 0, 0, 8'h11, 0);
    chk("R4", "store address", {f_we, f_addr}, {1'b1, 16'h0000});
    check_ptr(PY, 16'h0001, "R4");
  endtask

  task automatic t_predec;
    set_ptr(5'd30, 16'h0000);
    do_op(PREDEC, PZ, 1, 0, 0, 0, 8'hC3, 0);
    chk("R5", "address decremented first", 32'(f_addr), 32'hFFFF);
    chk("R7", "store strobe/data", {f_we, f_re, f_wd}, {2'b10, 8'hC3});
    chk("R7", "store cycles, no write-back", {8'(ncyc), 7'b0, o_we}, {8'd2, 8'd0});
    check_ptr(PZ, 16'hFFFF, "R5");
    chk("R5", "stored byte read back", 32'(o_wdata), 32'hC3);
  endtask

  task automatic t_disp;
    set_ptr(5'd28, 16'h0100);
    do_op(DISP, PY, 0, 6'd63, 0, 5'd6, 0, 0);
    chk("R6", "address ptr+63", 32'(f_addr), 32'h013F);
    chk("R6", "loaded byte", 32'(o_wdata), 32'(dinit(8'h3F)));
    check_ptr(PY, 16'h0100, "R6");
    do_op(DISP, PZ, 0, 6'd1, 0, 5'd6, 0, 0);
    chk("R6", "address wraps", 32'(f_addr), 32'h0000);
    check_ptr(PZ, 16'hFFFF, "R6");
  endtask

  task automatic t_direct;
    do_op(DIRECT, PX, 1, 0, 16'h0020, 0, 8'hA5, 0);
    chk("R7", "direct store address", {f_we, f_addr}, {1'b1, 16'h0020});
    chk("R7", "no write-back", 32'(o_we), 0);
    do_op(DIRECT, PX, 0, 0, 16'h0020, 5'd7, 0, 0);
    chk("R7", "direct load data", {o_waddr, o_wdata}, {5'd7, 16'h00A5});
    check_ptr(PX, 16'h0040, "R7");
  endtask

  task automatic t_prog;
    logic [15:0] w3 = pinit(3), w4 = pinit(4);
    set_ptr(5'd30, 16'h0007);
    do_op(PROG, PX, 0, 0, 0, 5'd3, 0, 0);
    chk("R9", "word address", {f_pre, 1'b0, f_paddr}, {1'b1, 1'b0, 15'd3});
    chk("R9", "cycles", ncyc, 3);
    chk("R9", "high byte", {o_waddr, o_wdata}, {5'd3, 8'h00, w3[15:8]});
    check_ptr(PZ, 16'h0007, "R9");
    do_op(PROG_R0, PX, 0, 0, 0, 5'd9, 0, 0);
    chk("R9", "implicit register 0", {o_we, o_waddr}, {1'b1, 5'd0});
    do_op(PROG_INC, PX, 0, 0, 0, 5'd2, 0, 0);
    chk("R9", "inc variant data", 32'(o_wdata), {16'h0, 8'h00, w3[15:8]});
    check_ptr(PZ, 16'h0008, "R9");
    do_op(PROG, PX, 0, 0, 0, 5'd2, 0, 0);
    chk("R9", "low byte next word", {1'b0, f_paddr, o_wdata}, {1'b0, 15'd4, 8'h00, w4[7:0]});
  endtask

  task automatic t_ptr_wb;
    do_op(PLAIN, PX, 0, 0, 0, 5'd31, 0, 0);
    check_ptr(PZ, {dinit(8'h40), 8'h08}, "R2");
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      total++; failn++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", total - failn, total);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_copy();
    t_plain();
    t_postinc();
    t_predec();
    t_disp();
    t_direct();
    t_prog();
    t_ptr_wb();
    finished = 1;
    $display("%0d/%0d checks passed", total - failn, total);
    $finish;
  end
endmodule